// File: doc/BRIEF.md
# Memory Operation Ordering Buffer

This block holds in-flight loads and stores between the issue stage and a single memory port. Each operation arrives with a base register value and an immediate offset; the block adds them when the operation is accepted, so effective addresses are formed in issue (program) order. Loads sit in one set of buffers and stores in another. A store may be accepted before its data exists; it then waits for a producer tag to appear on the result broadcast bus and copies the value from there.

Every cycle the block looks at all buffered operations and offers the oldest one that is free of an address conflict to the memory port. A load waits only behind older stores to the same address. A store waits behind any older load or store to the same address and, in addition, until its data is present. Operations to different addresses overtake each other freely. A load's value comes back from memory one cycle after its memory handshake and is broadcast with the load buffer number as its tag.

The issue side is valid/ready: an operation is taken on a cycle where `in_valid` and `in_ready` are both high, and `in_ready` reflects the kind requested in that cycle, so it may change when `in_store` changes. The memory side is valid/ready as well: an operation leaves its buffer only on a handshake. While the port is stalled `mem_valid` stays high, but the offered operation may be replaced by an older one that has just become eligible. The broadcast input and the load result output have no back-pressure.

Top module: `memop_order_buf`

## Requirements
- R1: The memory address of an operation equals `in_base + in_offset` taken modulo 2^ADDR_W, as sampled on its issue handshake.
- R2: `in_ready` is high exactly when a buffer of the requested kind (load when `in_store`=0, store when `in_store`=1) is free; the lowest-numbered free buffer of that kind is taken, and `issue_tag` gives its number (loads 0..NLD-1, stores 0..NST-1) in the same cycle.
- R3: A load is never offered to memory while an older store to the same address is still buffered.
- R4: A store is never offered to memory while an older load or older store to the same address is still buffered.
- R5: Among the buffered operations that are not held back by R3, R4 or R6, the oldest is offered; `mem_valid` is high whenever such an operation exists, and `mem_store` is 1 for a store, 0 for a load.
- R6: A store is eligible only once its data is present: given with `in_dready`=1 at issue, or copied from `bc_data` on a cycle where `bc_valid` is high and `bc_tag` equals its producer tag; `mem_wdata` carries that value. Broadcasts with tags no waiting store holds have no effect.
- R7: `res_valid` is high exactly in the cycle after a load handshake on the memory port, with `res_tag` equal to that load's buffer number and `res_data` equal to `mem_rdata` of that cycle.
- R8: An operation leaves its buffer only on a memory handshake; the buffer can be issued into again in the next cycle, and a stalled offer (`mem_valid` high, `mem_ready` low) is followed by `mem_valid` high.
- R9: After reset all buffers are empty: `mem_valid` and `res_valid` are low and `in_ready` is high.
- R10: Every load returns the value written by the most recent store, older in issue order, to the same address (zero if there is none).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue request valid |
| in_ready | output | 1 | A buffer of the requested kind is free |
| in_store | input | 1 | 1 = store, 0 = load |
| in_base | input | ADDR_W | Base register value |
| in_offset | input | ADDR_W | Immediate offset |
| in_dready | input | 1 | Store data is present in `in_data` |
| in_data | input | DATA_W | Store data (used when `in_dready`=1) |
| in_ptag | input | PTAG_W | Producer tag of store data (used when `in_dready`=0) |
| issue_tag | output | TAG_W | Buffer number taken by this issue |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | PTAG_W | Result broadcast producer tag |
| bc_data | input | DATA_W | Result broadcast value |
| mem_valid | output | 1 | Memory request offered |
| mem_ready | input | 1 | Memory accepts the request |
| mem_store | output | 1 | Offered request is a store |
| mem_addr | output | ADDR_W | Offered request address |
| mem_wdata | output | DATA_W | Store write data |
| mem_rdata | input | DATA_W | Load data, valid one cycle after a load handshake |
| res_valid | output | 1 | Load result valid |
| res_tag | output | TAG_W | Load buffer number of the result |
| res_data | output | DATA_W | Load result value |

## Verification
`in_ready` and `issue_tag` are combinational and checked in the same cycle as the request; an accepted operation, and a store whose data arrives on the broadcast bus, can first appear on the memory port in the following cycle, and a load's result is due exactly one cycle after its memory handshake. The bench drives inputs on the falling edge, samples the outputs 1 ns later, and only then advances its own model by one clock edge, so every comparison sees exactly the state produced by the edges already taken. The model keeps an issue sequence number per operation, recomputes the expected offer every cycle, and holds a program-order shadow memory to know each load's correct value.

// File: rtl/memop_pkg.sv
package memop_pkg;
  typedef enum logic {
    MO_LOAD  = 1'b0,
    MO_STORE = 1'b1
  } memop_kind_e;

  function automatic int min1_clog2(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/memop_age_track.sv
module memop_age_track #(
  parameter int N     = 5,
  parameter int AGE_W = 3,
  parameter int IDX_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N-1:0]              busy,
  input  logic                      alloc,
  input  logic [IDX_W-1:0]          alloc_idx,
  input  logic                      free,
  input  logic [IDX_W-1:0]          free_idx,
  output logic [N-1:0][AGE_W-1:0]   age
);
  // age = number of buffered entries younger than this one
  logic [AGE_W-1:0] free_age;
  assign free_age = age[free_idx];

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rst_n) begin
        age[i] <= '0;
      end else if (alloc && alloc_idx == IDX_W'(i)) begin
        age[i] <= '0;
      end else if (busy[i]) begin
        age[i] <= age[i] + AGE_W'(alloc)
                  - AGE_W'(free && age[i] > free_age);
      end
    end
  end

  for (genvar a = 0; a < N; a++) begin : g_a
    for (genvar b = a + 1; b < N; b++) begin : g_b
      // R5
      age_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy[a] && busy[b]) |-> (age[a] != age[b]));
    end
    // R5
    age_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy[a] |-> (age[a] < AGE_W'(N)));
  end
endmodule

// File: rtl/memop_conflict.sv
module memop_conflict #(
  parameter int N      = 5,
  parameter int NLD    = 3,
  parameter int ADDR_W = 16,
  parameter int AGE_W  = 3
) (
  input  logic [N-1:0]              busy,
  input  logic [N-1:0][ADDR_W-1:0]  addr,
  input  logic [N-1:0][AGE_W-1:0]   age,
  output logic [N-1:0]              blocked
);
  // entries 0..NLD-1 are loads, the rest stores
  for (genvar gi = 0; gi < N; gi++) begin : g_ent
    always_comb begin
      blocked[gi] = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (j != gi && busy[j] && age[j] > age[gi] && addr[j] == addr[gi]
            && (j >= NLD || gi >= NLD))
          blocked[gi] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/memop_age_pick.sv
module memop_age_pick #(
  parameter int N     = 5,
  parameter int AGE_W = 3,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]             elig,
  input  logic [N-1:0][AGE_W-1:0]  age,
  output logic                     any,
  output logic [IDX_W-1:0]         sel
);
  logic [AGE_W-1:0] best;

  always_comb begin
    any  = 1'b0;
    sel  = '0;
    best = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!any || age[i] > best)) begin
        any  = 1'b1;
        sel  = IDX_W'(i);
        best = age[i];
      end
    end
  end
endmodule

// File: rtl/memop_order_buf.sv
module memop_order_buf
  import memop_pkg::*;
#(
  parameter int NLD    = 3,
  parameter int NST    = 2,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int PTAG_W = 4,
  localparam int TAG_W = min1_clog2((NLD > NST) ? NLD : NST)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_store,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [ADDR_W-1:0] in_offset,
  input  logic              in_dready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [PTAG_W-1:0] in_ptag,
  output logic [TAG_W-1:0]  issue_tag,
  input  logic              bc_valid,
  input  logic [PTAG_W-1:0] bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_store,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              res_valid,
  output logic [TAG_W-1:0]  res_tag,
  output logic [DATA_W-1:0] res_data
);
  localparam int N     = NLD + NST;
  localparam int IDX_W = min1_clog2(N);
  localparam int AGE_W = min1_clog2(N);
  localparam int LD_W  = min1_clog2(NLD);
  localparam int ST_W  = min1_clog2(NST);
  localparam logic [IDX_W-1:0] NLD_I = IDX_W'(NLD);

  logic [N-1:0]              busy_q;
  logic [N-1:0][ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]         sdata_q [NST];
  logic [NST-1:0]            srdy_q;
  logic [PTAG_W-1:0]         sptag_q [NST];
  logic [N-1:0][AGE_W-1:0]   age;
  logic [N-1:0]              blocked, elig;

  logic              ld_free_any, st_free_any;
  logic [LD_W-1:0]   ld_free_idx;
  logic [ST_W-1:0]   st_free_idx, st_sel;
  logic              alloc, send, any;
  logic [IDX_W-1:0]  alloc_idx, sel;
  logic [ADDR_W-1:0] eff_addr;
  memop_kind_e       kind;
  logic [LD_W-1:0]   res_q;

  // lowest free buffer of each kind
  always_comb begin
    ld_free_any = 1'b0;
    ld_free_idx = '0;
    for (int i = NLD - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        ld_free_any = 1'b1;
        ld_free_idx = LD_W'(i);
      end
    end
    st_free_any = 1'b0;
    st_free_idx = '0;
    for (int i = NST - 1; i >= 0; i--) begin
      if (!busy_q[NLD+i]) begin
        st_free_any = 1'b1;
        st_free_idx = ST_W'(i);
      end
    end
  end

  assign kind      = memop_kind_e'(in_store);
  assign in_ready  = (kind == MO_STORE) ? st_free_any : ld_free_any;
  assign issue_tag = (kind == MO_STORE) ? TAG_W'(st_free_idx) : TAG_W'(ld_free_idx);
  assign alloc     = in_valid && in_ready;
  assign alloc_idx = (kind == MO_STORE) ? (NLD_I + IDX_W'(st_free_idx))
                                        : IDX_W'(ld_free_idx);
  assign eff_addr  = in_base + in_offset;

  memop_age_track #(.N(N), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_age (
    .clk(clk), .rst_n(rst_n), .busy(busy_q), .alloc(alloc), .alloc_idx(alloc_idx),
    .free(send), .free_idx(sel), .age(age));

  memop_conflict #(.N(N), .NLD(NLD), .ADDR_W(ADDR_W), .AGE_W(AGE_W)) u_conf (
    .busy(busy_q), .addr(addr_q), .age(age), .blocked(blocked));

  for (genvar g = 0; g < N; g++) begin : g_elig
    if (g < NLD) begin : g_ld
      assign elig[g] = busy_q[g] && !blocked[g];
    end else begin : g_st
      assign elig[g] = busy_q[g] && !blocked[g] && srdy_q[g-NLD];
    end
  end

  memop_age_pick #(.N(N), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_pick (
    .elig(elig), .age(age), .any(any), .sel(sel));

  assign st_sel    = ST_W'(sel - NLD_I);
  assign mem_valid = any;
  assign mem_store = (sel >= NLD_I);
  assign mem_addr  = addr_q[sel];
  assign mem_wdata = mem_store ? sdata_q[st_sel] : '0;
  assign send      = mem_valid && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= '0;
      addr_q    <= '0;
      srdy_q    <= '0;
      res_valid <= 1'b0;
      res_q     <= '0;
      for (int s = 0; s < NST; s++) begin
        sdata_q[s] <= '0;
        sptag_q[s] <= '0;
      end
    end else begin
      res_valid <= send && !mem_store;
      if (send && !mem_store) res_q <= LD_W'(sel);
      for (int i = 0; i < N; i++) begin
        if (send && sel == IDX_W'(i)) busy_q[i] <= 1'b0;
        if (alloc && alloc_idx == IDX_W'(i)) begin
          busy_q[i] <= 1'b1;
          addr_q[i] <= eff_addr;
        end
      end
      for (int s = 0; s < NST; s++) begin
        if (alloc && alloc_idx == IDX_W'(NLD + s)) begin
          sptag_q[s] <= in_ptag;
          srdy_q[s]  <= in_dready || (bc_valid && bc_tag == in_ptag);
          sdata_q[s] <= in_dready ? in_data : bc_data;
        end else if (busy_q[NLD+s] && !srdy_q[s] && bc_valid && bc_tag == sptag_q[s]) begin
          srdy_q[s]  <= 1'b1;
          sdata_q[s] <= bc_data;
        end
      end
    end
  end

  assign res_tag  = TAG_W'(res_q);
  assign res_data = mem_rdata;

  // R7
  res_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !mem_store) |=> res_valid);
  // R7
  res_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid && mem_ready && !mem_store) |=> !res_valid);
  // R6
  st_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_store) |-> srdy_q[st_sel]);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> mem_valid);
  // R2
  issue_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !busy_q[alloc_idx]);
endmodule

// File: tb/tb_memop_order_buf.sv
`timescale 1ns/1ps
module tb_memop_order_buf;
  localparam int NLD = 3, NST = 2, N = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        in_valid = 0, in_ready, in_store = 0, in_dready = 0;
  logic [15:0] in_base = 0, in_offset = 0, mem_addr;
  logic [31:0] in_data = 0, bc_data = 0, mem_wdata, mem_rdata = 0, res_data;
  logic [3:0]  in_ptag = 0, bc_tag = 0;
  logic [1:0]  issue_tag, res_tag;
  logic        bc_valid = 0, mem_valid, mem_ready = 0, mem_store, res_valid;

  memop_order_buf dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_store(in_store),
    .in_base(in_base), .in_offset(in_offset), .in_dready(in_dready), .in_data(in_data),
    .in_ptag(in_ptag), .issue_tag(issue_tag), .bc_valid(bc_valid), .bc_tag(bc_tag),
    .bc_data(bc_data), .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_store(mem_store),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data));

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  bit          mb [N];
  logic [15:0] ma [N];
  bit          mrdy [N];
  logic [31:0] md [N];
  logic [3:0]  mpt [N];
  int          mseq [N];
  logic [31:0] mexp [NLD];
  int          seqc = 0;
  logic [31:0] shadow [logic [15:0]];
  logic [31:0] tbmem [logic [15:0]];
  bit          rexp_v = 0;
  int          rexp_tag = 0;
  logic [31:0] rexp_d = 0, pend_rdata = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_shadow(input logic [15:0] a);
    return shadow.exists(a) ? shadow[a] : 32'h0;
  endfunction
  function automatic logic [31:0] rd_mem(input logic [15:0] a);
    return tbmem.exists(a) ? tbmem[a] : 32'h0;
  endfunction
  function automatic bit tag_waiting(input logic [3:0] t);
    for (int i = NLD; i < N; i++)
      if (mb[i] && !mrdy[i] && mpt[i] == t) return 1'b1;
    return 1'b0;
  endfunction

  task automatic step(input bit allow_issue);
    int r, best, fidx;
    bit send, rv_n;
    @(negedge clk);
    // broadcast stimulus
    bc_valid = 0;
    r = $urandom % 100;
    if (r < 30) begin
      int st = $urandom % NST;
      for (int k = 0; k < NST; k++) begin
        int ix = NLD + (st + k) % NST;
        if (!bc_valid && mb[ix] && !mrdy[ix]) begin
          bc_valid = 1; bc_tag = mpt[ix]; bc_data = md[ix];
        end
      end
    end else if (r < 40) begin
      // R6: tag nobody waits for
      logic [3:0] t = 4'($urandom);
      while (tag_waiting(t)) t = t + 1;
      bc_valid = 1; bc_tag = t; bc_data = $urandom;
    end
    // issue stimulus
    in_valid = allow_issue && ($urandom % 100 < 60);
    in_store = $urandom % 2;
    case ($urandom % 3)
      0: in_base = 16'h0040;
      1: in_base = 16'h003E;
      default: in_base = 16'hFFFE;
    endcase
    in_offset = 16'($urandom % 4);
    in_dready = $urandom % 2;
    in_data   = $urandom;
    in_ptag   = 4'($urandom);
    while (tag_waiting(in_ptag) || (bc_valid && bc_tag == in_ptag)) in_ptag = in_ptag + 1;
    mem_ready = ($urandom % 100 < 70);
    mem_rdata = pend_rdata;
    #1;
    // R2: expected allocation
    fidx = -1;
    if (in_store) begin
      for (int i = NST - 1; i >= 0; i--) if (!mb[NLD+i]) fidx = i;
    end else begin
      for (int i = NLD - 1; i >= 0; i--) if (!mb[i]) fidx = i;
    end
    chk(in_ready == (fidx >= 0), "R2 R8", "in_ready", in_ready, fidx >= 0);
    if (in_valid && fidx >= 0) chk(issue_tag == fidx, "R2", "issue_tag", issue_tag, fidx);
    // expected memory offer
    best = -1;
    for (int i = 0; i < N; i++) begin
      if (mb[i] && (i < NLD || mrdy[i])) begin
        bit blk = 0;
        for (int j = 0; j < N; j++)
          if (j != i && mb[j] && mseq[j] < mseq[i] && ma[j] == ma[i] && (j >= NLD || i >= NLD))
            blk = 1;
        if (!blk && (best < 0 || mseq[i] < mseq[best])) best = i;
      end
    end
    chk(mem_valid == (best >= 0), "R5", "mem_valid", mem_valid, best >= 0);
    if (best >= 0 && mem_valid) begin
      chk(mem_store == (best >= NLD), "R3 R4", "mem_store", mem_store, best >= NLD);
      chk(mem_addr == ma[best], "R1", "mem_addr", mem_addr, ma[best]);
      if (best >= NLD) chk(mem_wdata == md[best], "R6", "mem_wdata", mem_wdata, md[best]);
    end
    // R7 / R10: load result
    chk(res_valid == rexp_v, "R7", "res_valid", res_valid, rexp_v);
    if (rexp_v && res_valid) begin
      chk(res_tag == rexp_tag, "R7", "res_tag", res_tag, rexp_tag);
      chk(res_data == rexp_d, "R10", "res_data", res_data, rexp_d);
    end
    // advance model across the coming edge
    send = (best >= 0) && mem_ready;
    rv_n = 0;
    if (send) begin
      mb[best] = 0;
      if (best >= NLD) tbmem[ma[best]] = md[best];
      else begin
        rv_n = 1; rexp_tag = best; rexp_d = mexp[best];
        pend_rdata = rd_mem(ma[best]);
      end
    end
    rexp_v = rv_n;
    for (int i = NLD; i < N; i++)
      if (mb[i] && !mrdy[i] && bc_valid && mpt[i] == bc_tag) mrdy[i] = 1;
    if (in_valid && fidx >= 0) begin
      int k = in_store ? NLD + fidx : fidx;
      logic [15:0] a = in_base + in_offset;
      mb[k] = 1; ma[k] = a; mrdy[k] = in_dready; md[k] = in_data; mpt[k] = in_ptag;
      mseq[k] = seqc; seqc++;
      if (in_store) shadow[a] = in_data;
      else mexp[k] = rd_shadow(a);
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      mb[i] = 0; ma[i] = 0; mrdy[i] = 0; md[i] = 0; mpt[i] = 0; mseq[i] = 0;
    end
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready == 1'b1, "R9", "in_ready in reset", in_ready, 1);
    chk(mem_valid == 1'b0, "R9", "mem_valid in reset", mem_valid, 0);
    chk(res_valid == 1'b0, "R9", "res_valid in reset", res_valid, 0);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk(mem_valid == 1'b0 && in_ready == 1'b1, "R9", "idle after reset",
        {mem_valid, in_ready}, 2'b01);
    for (int c = 0; c < 4000; c++) step(1'b1);
    for (int c = 0; c < 400; c++) begin
      bit empty = !rexp_v;
      for (int i = 0; i < N; i++) if (mb[i]) empty = 0;
      if (!empty) step(1'b0);
    end
    begin
      int left = 0;
      for (int i = 0; i < N; i++) if (mb[i]) left++;
      chk(left == 0, "R8", "buffers drained", left, 0);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule